// File: doc/BRIEF.md
# Circular-Buffer DMA Channel with Automatic Rewind

This block is one DMA channel that shuttles single units of data between a walking memory pointer and a fixed peripheral address. Each activation request produces exactly one bus transfer. After every transfer the 24-bit memory pointer moves by one unit, either upward or downward. An 8-bit working counter counts the transfers in the current pass.

When the working counter is exhausted, it is refilled from a held copy of the pass length. In the same step the memory pointer is wound back to the start of the buffer. The rewind is computed from the pass length, the unit size and the step direction. The channel therefore serves a circular buffer indefinitely without software involvement, and it raises no completion event. Software stops the channel by clearing the enable bit. Setting the bit again continues from exactly the pointer and count that were in place when the channel stopped.

The transfer request leaves the block as a valid/ready stream. The channel raises `bus_valid` and holds `bus_valid` and every transfer field steady until the cycle in which `bus_ready` is high. That cycle is the transfer, and the pointer and counter advance at its end. While `bus_ready` stays low the channel simply waits. One further activation request can be latched during that wait.

Top module: `rpt_dma_channel`

## Requirements
- R1: After reset `bus_valid` is 0, and the memory pointer, peripheral address, working counter, held count and all control bits are 0.
- R2: A write with `cfg_we`=1 loads one register selected by `cfg_sel`, as follows. Selector 0 loads the memory pointer from `cfg_wdata[23:0]`. Selector 1 loads the peripheral address from `cfg_wdata[7:0]`. Selector 2 loads the working counter from `cfg_wdata[7:0]`. Selector 3 loads the held count from `cfg_wdata[7:0]`. Selector 4 loads the control bits: bit 0 enable, bit 1 step down, bit 2 word unit, bit 3 memory-is-destination. The peripheral address appears unchanged on `bus_io_addr` in every transfer.
- R3: A one-cycle `act_req` while the channel is enabled and idle makes `bus_valid` rise two clock edges later. Each request yields exactly one transfer.
- R4: Each completed transfer moves the memory pointer by 1 (byte unit) or 2 (word unit). It moves upward when step down is 0 and downward when it is 1, wrapping modulo 2^24.
- R5: Each transfer decrements the working counter. A transfer that finds the counter at 1 instead reloads it from the held count and returns the pointer to the value it had at the start of the pass. Transfers then go on with no completion signal.
- R6: A held count (and working counter) of 0 means a pass of 256 transfers.
- R7: `bus_mem_write` equals the memory-is-destination control bit. A value of 1 means memory is written and the peripheral is read; 0 means the reverse. `bus_word` equals the word-unit bit.
- R8: While enable is 0, `act_req` is ignored, and a request not yet issued is discarded. No transfer starts after re-enabling unless a new request arrives.
- R9: Clearing and later setting enable leaves the pointer and counter untouched, so the next transfer continues the pass where it stopped.
- R10: While `bus_valid`=1 and `bus_ready`=0, `bus_valid`, `bus_mem_addr`, `bus_io_addr`, `bus_mem_write` and `bus_word` hold their values.
- R11: One request arriving while a transfer waits is latched and issued right after it. Any further requests in that wait merge into that single latched request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 24 | Register write data |
| act_req | input | 1 | Activation request, one transfer per pulse |
| bus_valid | output | 1 | Transfer request valid |
| bus_ready | input | 1 | Bus accepts the transfer this cycle |
| bus_mem_addr | output | 24 | Memory side address of the transfer |
| bus_io_addr | output | 8 | Peripheral side address of the transfer |
| bus_mem_write | output | 1 | 1: memory is destination; 0: memory is source |
| bus_word | output | 1 | 1: 16-bit unit; 0: byte unit |

## Verification
The following properties are checked on every cycle:
- the stream stays stable under back-pressure;
- a new transfer appears only after an enabled request;
- requests are dropped while the channel is disabled;
- the counter steps down by one or reloads from the held count;
- the pointer moves by exactly one unit per non-final transfer;
- pointer and counter are frozen whenever no transfer completes.

Only the bench scenarios can show the following:
- that the rewind lands back on the first address of the pass for several sizes, directions and 24-bit wraps;
- that a held count of zero gives a 256-transfer pass;
- that a pause continues mid-pass;
- that several requests queued behind a stalled transfer collapse into exactly one.

// File: rtl/rpt_dma_pkg.sv
package rpt_dma_pkg;

  typedef enum logic [2:0] {
    SEL_MEM  = 3'd0,
    SEL_IO   = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_HOLD = 3'd3,
    SEL_CTRL = 3'd4
  } cfg_sel_e;

  // control word, enable in bit 0
  typedef struct packed {
    logic rx_dst;
    logic word;
    logic down;
    logic en;
  } ctl_t;

endpackage

// File: rtl/rpt_dma_regs.sv
module rpt_dma_regs
  import rpt_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              xfer,
  output logic [ADDR_W-1:0] mar,
  output logic [IO_W-1:0]   ioar,
  output ctl_t              ctl
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W:0]   FULL_PASS = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  hold_q;
  logic              last;
  logic [CNT_W:0]    hold_eff;
  logic [ADDR_W-1:0] unit;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] mar_d;
  logic              we_mem, we_io, we_cnt, we_hold, we_ctl;

  assign we_mem  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_MEM);
  assign we_io   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_IO);
  assign we_cnt  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CNT);
  assign we_hold = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_HOLD);
  assign we_ctl  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL);

  assign last = (cnt_q == CNT_ONE);

  // next pointer: one unit step, plus a rewind over the whole pass on the final transfer
  always_comb begin
    unit     = ctl.word ? ADDR_W'(2) : ADDR_W'(1);
    hold_eff = (hold_q == '0) ? FULL_PASS : {1'b0, hold_q};
    span     = ADDR_W'(hold_eff) << ctl.word;
    stepped  = ctl.down ? (mar - unit) : (mar + unit);
    if (last) mar_d = ctl.down ? (stepped + span) : (stepped - span);
    else      mar_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar    <= '0;
      ioar   <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      ctl    <= '0;
    end else begin
      if (we_mem)    mar <= cfg_wdata;
      else if (xfer) mar <= mar_d;

      if (we_cnt)    cnt_q <= cfg_wdata[CNT_W-1:0];
      else if (xfer) cnt_q <= last ? hold_q : (cnt_q - CNT_ONE);

      if (we_io)   ioar   <= cfg_wdata[IO_W-1:0];
      if (we_hold) hold_q <= cfg_wdata[CNT_W-1:0];
      if (we_ctl)  ctl    <= ctl_t'(cfg_wdata[3:0]);
    end
  end

  a_r5_reload_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last && !cfg_we) |=> (cnt_q == $past(hold_q)));

  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last && !cfg_we) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  a_r4_one_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last && !cfg_we) |=>
      ($past(ctl.down) ? (($past(mar) - mar) == $past(unit))
                       : ((mar - $past(mar)) == $past(unit))));

  a_r9_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !cfg_we) |=> ($stable(mar) && $stable(cnt_q)));

endmodule

// File: rtl/rpt_dma_req.sv
module rpt_dma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic act_req,
  input  logic busy,
  output logic issue
);

  logic pending_q;

  assign issue = pending_q && enable && !busy;

  // a single latch slot: further requests merge, disable drops it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= enable && (act_req || (pending_q && !issue));
  end

  a_r8_drop_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pending_q);

  a_r11_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);

endmodule

// File: rtl/rpt_dma_bus.sv
module rpt_dma_bus (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic bus_ready,
  output logic bus_valid,
  output logic xfer
);

  assign xfer = bus_valid && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_valid <= 1'b0;
    else if (issue) bus_valid <= 1'b1;
    else if (xfer)  bus_valid <= 1'b0;
  end

  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid);

  a_r3_rise_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(issue));

endmodule

// File: rtl/rpt_dma_channel.sv
module rpt_dma_channel
  import rpt_dma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              act_req,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_mem_addr,
  output logic [IO_W-1:0]   bus_io_addr,
  output logic              bus_mem_write,
  output logic              bus_word
);

  logic              issue;
  logic              xfer;
  logic [ADDR_W-1:0] mar;
  logic [IO_W-1:0]   ioar;
  ctl_t              ctl;

  rpt_dma_regs #(
    .ADDR_W(ADDR_W),
    .IO_W  (IO_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .xfer     (xfer),
    .mar      (mar),
    .ioar     (ioar),
    .ctl      (ctl)
  );

  rpt_dma_req u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ctl.en),
    .act_req(act_req),
    .busy   (bus_valid),
    .issue  (issue)
  );

  rpt_dma_bus u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .bus_ready(bus_ready),
    .bus_valid(bus_valid),
    .xfer     (xfer)
  );

  assign bus_mem_addr  = mar;
  assign bus_io_addr   = ioar;
  assign bus_mem_write = ctl.rx_dst;
  assign bus_word      = ctl.word;

  a_r10_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !cfg_we) |=>
      ($stable(bus_mem_addr) && $stable(bus_io_addr) &&
       $stable(bus_mem_write) && $stable(bus_word)));

  a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(ctl.en));

endmodule

// File: tb/rpt_dma_channel_bench.sv
`timescale 1ns/1ps
module rpt_dma_channel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        act_req = 1'b0;
  logic        bus_ready = 1'b0;
  logic        bus_valid;
  logic [23:0] bus_mem_addr;
  logic [7:0]  bus_io_addr;
  logic        bus_mem_write;
  logic        bus_word;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  rpt_dma_channel u_rpt_dma_channel (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .act_req      (act_req),
    .bus_valid    (bus_valid),
    .bus_ready    (bus_ready),
    .bus_mem_addr (bus_mem_addr),
    .bus_io_addr  (bus_io_addr),
    .bus_mem_write(bus_mem_write),
    .bus_word     (bus_word)
  );

  typedef struct packed {
    logic [23:0] start;
    logic [7:0]  io;
    logic [7:0]  n;
    logic        down;
    logic        word;
    logic        rx;
    logic [7:0]  ntr;
    logic [23:0] nxt;
  } vec_t;

  // start, io, pass length, down, word, rx, transfers, expected pointer afterwards
  localparam vec_t VT [5] = '{
    '{24'h001000, 8'h40, 8'd4, 1'b0, 1'b0, 1'b1, 8'd6, 24'h001002},
    '{24'h002000, 8'h81, 8'd3, 1'b1, 1'b1, 1'b0, 8'd5, 24'h001FFC},
    '{24'hFFFFFE, 8'h10, 8'd2, 1'b0, 1'b1, 1'b1, 8'd3, 24'h000000},
    '{24'h000001, 8'hFF, 8'd3, 1'b1, 1'b0, 1'b0, 8'd4, 24'h000000},
    '{24'h000000, 8'h22, 8'd2, 1'b1, 1'b0, 1'b1, 8'd1, 24'hFFFFFF}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [23:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    act_req = 1'b1;
    @(negedge clk);
    act_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take(input string rq, input logic [23:0] ea, input logic [7:0] eio,
                      input logic ewr, input logic eword);
    for (int i = 0; i < 8 && !bus_valid; i++) @(negedge clk);
    chk("R3", "bus_valid", 32'(bus_valid), 32'd1);
    chk(rq, "bus_mem_addr", 32'(bus_mem_addr), 32'(ea));
    chk("R2", "bus_io_addr", 32'(bus_io_addr), 32'(eio));
    chk("R7", "bus_mem_write", 32'(bus_mem_write), 32'(ewr));
    chk("R7", "bus_word", 32'(bus_word), 32'(eword));
    bus_ready = 1'b1;
    @(negedge clk);
    bus_ready = 1'b0;
  endtask

  task automatic setup(input logic [23:0] st, input logic [7:0] io, input logic [7:0] n,
                       input logic dn, input logic wd, input logic rx);
    wr(3'd4, 24'h0);
    wr(3'd0, st);
    wr(3'd1, {16'h0, io});
    wr(3'd2, {16'h0, n});
    wr(3'd3, {16'h0, n});
    wr(3'd4, {20'h0, rx, wd, dn, 1'b1});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [23:0] off;
    logic [23:0] ea;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: idle after reset; disabled channel ignores requests (R8)
    chk("R1", "bus_valid after reset", 32'(bus_valid), 32'd0);
    pulse_req();
    idle(4);
    chk("R8", "no transfer while disabled", 32'(bus_valid), 32'd0);
    // R1: enable only; all other registers still at reset value
    wr(3'd4, 24'h000001);
    pulse_req();
    take("R1", 24'h0, 8'h0, 1'b0, 1'b0);

    // table walk: R4 stepping, R5 rewind after the pass
    for (int v = 0; v < 5; v++) begin
      setup(VT[v].start, VT[v].io, VT[v].n, VT[v].down, VT[v].word, VT[v].rx);
      for (int k = 0; k < int'(VT[v].ntr); k++) begin
        off = 24'(k % int'(VT[v].n)) << VT[v].word;
        ea  = VT[v].down ? (VT[v].start - off) : (VT[v].start + off);
        pulse_req();
        take("R4", ea, VT[v].io, VT[v].rx, VT[v].word);
      end
      pulse_req();
      take("R5", VT[v].nxt, VT[v].io, VT[v].rx, VT[v].word);
    end

    // R8: pending request discarded by disable
    setup(24'h000500, 8'h33, 8'd4, 1'b0, 1'b0, 1'b0);
    wr(3'd4, 24'h000000);
    pulse_req();
    idle(4);
    chk("R8", "request ignored while disabled", 32'(bus_valid), 32'd0);
    wr(3'd4, 24'h000001);
    idle(4);
    chk("R8", "no stale transfer after re-enable", 32'(bus_valid), 32'd0);

    // R9: pause mid-pass and continue
    setup(24'h000100, 8'h44, 8'd4, 1'b0, 1'b0, 1'b0);
    pulse_req(); take("R9", 24'h000100, 8'h44, 1'b0, 1'b0);
    pulse_req(); take("R9", 24'h000101, 8'h44, 1'b0, 1'b0);
    wr(3'd4, 24'h000000);
    idle(3);
    wr(3'd4, 24'h000001);
    pulse_req(); take("R9", 24'h000102, 8'h44, 1'b0, 1'b0);
    pulse_req(); take("R9", 24'h000103, 8'h44, 1'b0, 1'b0);
    pulse_req(); take("R5", 24'h000100, 8'h44, 1'b0, 1'b0);

    // R10 / R11: stall, queue extra requests
    setup(24'h000300, 8'h55, 8'd8, 1'b0, 1'b0, 1'b1);
    pulse_req();
    idle(2);
    pulse_req();
    pulse_req();
    idle(2);
    chk("R10", "valid held under back-pressure", 32'(bus_valid), 32'd1);
    chk("R10", "address held under back-pressure", 32'(bus_mem_addr), 32'h000300);
    take("R10", 24'h000300, 8'h55, 1'b1, 1'b0);
    take("R11", 24'h000301, 8'h55, 1'b1, 1'b0);
    idle(5);
    chk("R11", "extra requests merged", 32'(bus_valid), 32'd0);

    // R6: held count of zero gives a 256-transfer pass
    setup(24'h004000, 8'h66, 8'd0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 256; k++) begin
      pulse_req();
      take("R6", 24'h004000 + 24'(k), 8'h66, 1'b0, 1'b0);
    end
    pulse_req();
    take("R6", 24'h004000, 8'h66, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule